// File: doc/BRIEF.md
# Serial Link Code-Group Synchronizer

This block sits on the receive side of an 8b/10b serial link from a data converter. It comes after the deserializer and the 10b/8b decoder, and it takes one decoded character per clock. Each character arrives with a control flag and a code-error flag. The block holds an active-low synchronization request toward the transmitter until it has seen an unbroken run of comma characters. After releasing the request, it skips any trailing commas and treats the first non-comma character as the start of a frame. From then on it pairs characters into 16-bit samples. The first character of a frame is the most significant octet and the second is the least significant.

The core is a three-state machine:
- `REQ_SYNC`: the request is asserted and commas are counted.
- `WAIT_DATA`: the request is released and commas are discarded.
- `ALIGNED`: octet pairs are assembled into samples.

The named transitions are:
- `REQ_SYNC`→`WAIT_DATA` on the fourth consecutive valid comma.
- `WAIT_DATA`→`ALIGNED` on the first valid non-comma character.
- `WAIT_DATA`→`REQ_SYNC` and `ALIGNED`→`REQ_SYNC` on any code error, which is how a bit slip shows up.
- Reset enters `REQ_SYNC`.

Top module: `code_group_sync`

## Requirements
- R1: While reset is held and after its release, the block shows `sync_req_n`=0, `frame_locked`=0, `octet_pos`=0 and `smp_valid`=0.
- R2: A valid comma is `rx_is_ctrl`=1 with `rx_char`=8'hBC and `rx_code_err`=0. On the clock edge that accepts the fourth consecutive valid comma, `sync_req_n` goes to 1. It is registered, so it changes only at clock edges.
- R3: Any character that is not a valid comma restarts the comma count from zero while the request is asserted. This includes data 8'hBC with `rx_is_ctrl`=0 and any character with a code error.
- R4: After release, further valid commas are discarded. `sync_req_n` stays 1, `frame_locked` stays 0 and no sample is emitted.
- R5: The first valid non-comma character after release is taken as the most significant octet of a frame. On that edge `frame_locked` goes to 1 and `octet_pos` goes to 1.
- R6: While locked, `octet_pos` gives the position of the character expected next: 0 for the most significant octet, 1 for the least significant. It toggles on every error-free character.
- R7: On the edge that accepts the least significant octet, `smp_valid` pulses for one cycle and `smp_data` = {most significant octet, least significant octet}. `smp_data` holds its value otherwise.
- R8: While locked, the control flag is ignored. A K28.5 character is assembled as octet 8'hBC like any data.
- R9: A code error in `WAIT_DATA` or `ALIGNED` sets `sync_req_n`=0, `frame_locked`=0 and `octet_pos`=0 on that edge, and emits no sample. After that, four new consecutive commas are needed before release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_char | input | 8 | Decoded octet |
| rx_is_ctrl | input | 1 | Character is a control symbol |
| rx_code_err | input | 1 | Decoder found an invalid code group |
| sync_req_n | output | 1 | Registered active-low synchronization request |
| frame_locked | output | 1 | Block is in the aligned state |
| octet_pos | output | 1 | Expected position of the next character |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| smp_data | output | 16 | Assembled sample, first octet in the upper byte |

## Verification
The bench interrupts a comma run at three, once with a data 8'hBC and once with a code error. A counter that failed to restart would then release early. It sends extra commas after release, which a design that locked on the preamble would pair into bogus samples. It injects code errors both before lock and on a least-significant-octet position. A design that kept its lock or its count would emit a stale sample or release the request too soon. K28.5 characters inside aligned data check that the control flag no longer matters once the frame is locked.

// File: rtl/sync_pkg.sv
package sync_pkg;
    localparam logic [7:0] COMMA_OCTET = 8'hBC;

    typedef enum logic [1:0] {
        REQ_SYNC  = 2'd0,
        WAIT_DATA = 2'd1,
        ALIGNED   = 2'd2
    } sync_state_t;
endpackage

// File: rtl/comma_counter.sv
module comma_counter #(
    parameter int NEED = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic comma_in,
    output logic last_comma
);
    localparam int CW = $clog2(NEED + 1);

    logic [CW-1:0] cnt_q;

    assign last_comma = enable && comma_in && (cnt_q == CW'(NEED - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable || !comma_in || last_comma) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: count never reaches the limit and restarts on a broken run
    a_r3_count_below_need: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(NEED));
    a_r3_break_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !comma_in) |=> (cnt_q == '0));
endmodule

// File: rtl/sync_fsm.sv
module sync_fsm
    import sync_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        comma_in,
    input  logic        code_err,
    input  logic        last_comma,
    output sync_state_t state_o,
    output logic        sync_req_n
);
    sync_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_SYNC:  if (last_comma) state_d = WAIT_DATA;
            WAIT_DATA: begin
                if (code_err)       state_d = REQ_SYNC;
                else if (!comma_in) state_d = ALIGNED;
            end
            ALIGNED:   if (code_err) state_d = REQ_SYNC;
            default:   state_d = REQ_SYNC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_SYNC;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_req_n <= 1'b0;
        else        sync_req_n <= (state_d != REQ_SYNC);
    end

    assign state_o = state_q;

    // R2: release only follows the comma that completes the run
    a_r2_release_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_req_n) |-> $past(last_comma));
    // R9: a code error after release re-asserts the request
    a_r9_err_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (code_err && state_q != REQ_SYNC) |=> !sync_req_n);
endmodule

// File: rtl/octet_pair_assembler.sv
module octet_pair_assembler
    import sync_pkg::*;
#(
    parameter int OCT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sync_state_t        state,
    input  logic               comma_in,
    input  logic               code_err,
    input  logic [OCT_W-1:0]   rx_char,
    output logic               pos_o,
    output logic               smp_valid,
    output logic [2*OCT_W-1:0] smp_data
);
    logic             pos_q;
    logic [OCT_W-1:0] msb_q;
    logic             take_first, take_second;

    assign take_first  = !code_err &&
                         ((state == WAIT_DATA && !comma_in) ||
                          (state == ALIGNED && !pos_q));
    assign take_second = !code_err && state == ALIGNED && pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q     <= 1'b0;
            msb_q     <= '0;
            smp_valid <= 1'b0;
            smp_data  <= '0;
        end else begin
            pos_q     <= take_first;
            smp_valid <= take_second;
            if (take_first)  msb_q    <= rx_char;
            if (take_second) smp_data <= {msb_q, rx_char};
        end
    end

    assign pos_o = pos_q;

    // R6: position flips on every clean aligned character
    a_r6_pos_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ALIGNED && !code_err) |=> (pos_q != $past(pos_q)));
    // R7: strobe is a single-cycle pulse
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);
endmodule

// File: rtl/code_group_sync.sv
module code_group_sync
    import sync_pkg::*;
#(
    parameter int OCT_W      = 8,
    parameter int COMMA_NEED = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OCT_W-1:0]   rx_char,
    input  logic               rx_is_ctrl,
    input  logic               rx_code_err,
    output logic               sync_req_n,
    output logic               frame_locked,
    output logic               octet_pos,
    output logic               smp_valid,
    output logic [2*OCT_W-1:0] smp_data
);
    sync_state_t state;
    logic        is_comma;
    logic        last_comma;

    assign is_comma = rx_is_ctrl && !rx_code_err &&
                      (rx_char == OCT_W'(COMMA_OCTET));

    comma_counter #(.NEED(COMMA_NEED)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (state == REQ_SYNC),
        .comma_in   (is_comma),
        .last_comma (last_comma)
    );

    sync_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .comma_in   (is_comma),
        .code_err   (rx_code_err),
        .last_comma (last_comma),
        .state_o    (state),
        .sync_req_n (sync_req_n)
    );

    octet_pair_assembler #(.OCT_W(OCT_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .comma_in  (is_comma),
        .code_err  (rx_code_err),
        .rx_char   (rx_char),
        .pos_o     (octet_pos),
        .smp_valid (smp_valid),
        .smp_data  (smp_data)
    );

    assign frame_locked = (state == ALIGNED);

    // R4: commas after release never produce lock or samples
    a_r4_preamble_skipped: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WAIT_DATA && is_comma) |=> (!frame_locked && !smp_valid));
    // R5: lock means the request is released
    a_r5_lock_implies_release: assert property (@(posedge clk) disable iff (!rst_n)
        frame_locked |-> sync_req_n);
endmodule

// File: tb/sim_code_group_sync.sv
module sim_code_group_sync;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_char = 8'h00;
    logic        rx_is_ctrl = 1'b0;
    logic        rx_code_err = 1'b0;
    logic        sync_req_n, frame_locked, octet_pos, smp_valid;
    logic [15:0] smp_data;

    int n_tests = 0;
    int n_fail  = 0;

    // behavioural reference
    int        m_st = 0;      // 0 request, 1 waiting, 2 locked
    int        m_cnt = 0;
    bit        m_pos = 0;
    bit        m_valid = 0;
    bit [7:0]  m_msb = 0;
    bit [15:0] m_data = 0;

    always #5 clk = ~clk;

    code_group_sync u0 (
        .clk(clk), .rst_n(rst_n), .rx_char(rx_char), .rx_is_ctrl(rx_is_ctrl),
        .rx_code_err(rx_code_err), .sync_req_n(sync_req_n),
        .frame_locked(frame_locked), .octet_pos(octet_pos),
        .smp_valid(smp_valid), .smp_data(smp_data)
    );

    task automatic chk1(input string tag, input string what, input logic act, input bit exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk1(tag, "sync_req_n", sync_req_n, m_st != 0);
        chk1(tag, "frame_locked", frame_locked, m_st == 2);
        chk1(tag, "octet_pos", octet_pos, m_pos);
        chk1(tag, "smp_valid", smp_valid, m_valid);
        if (m_valid) begin
            n_tests++;
            if (smp_data !== m_data) begin
                n_fail++;
                $display("FAIL %s smp_data: actual %h expected %h", tag, smp_data, m_data);
            end
        end
    endtask

    task automatic model(input bit c, input bit [7:0] ch, input bit e);
        bit comma = c && !e && ch == 8'hBC;
        m_valid = 0;
        case (m_st)
            0: begin
                if (comma) begin
                    if (m_cnt == 3) begin m_st = 1; m_cnt = 0; end
                    else m_cnt++;
                end else m_cnt = 0;
            end
            1: begin
                if (e) m_st = 0;
                else if (!comma) begin m_msb = ch; m_pos = 1; m_st = 2; end
            end
            default: begin
                if (e) begin m_st = 0; m_pos = 0; end
                else if (!m_pos) begin m_msb = ch; m_pos = 1; end
                else begin m_data = {m_msb, ch}; m_valid = 1; m_pos = 0; end
            end
        endcase
    endtask

    // check outputs from the previous edge, then present one character
    task automatic step(input bit c, input bit [7:0] ch, input bit e, input string tag);
        @(negedge clk);
        compare(tag);
        rx_is_ctrl = c; rx_char = ch; rx_code_err = e;
        model(c, ch, e);
    endtask

    task automatic commas(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 8'hBC, 0, tag);
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        step(0, 8'h00, 0, "R1");
        // R3: run broken by data 0xBC, then by a code error
        commas(3, "R3");
        step(0, 8'hBC, 0, "R3");
        commas(3, "R3");
        step(1, 8'hBC, 1, "R3");
        commas(3, "R3");
        step(0, 8'h12, 0, "R3");
        // R2: four in a row release the request
        commas(4, "R2");
        // R4: trailing preamble discarded
        commas(3, "R4");
        // R5/R6/R7: frames
        step(0, 8'hA5, 0, "R5");
        step(0, 8'h3C, 0, "R6");
        step(0, 8'h01, 0, "R7");
        step(0, 8'hFE, 0, "R6");
        // R8: K28.5 treated as data while locked
        step(1, 8'hBC, 0, "R8");
        step(1, 8'hBC, 0, "R8");
        for (int i = 0; i < 6; i++) step(0, 8'(i * 37 + 5), 0, "R7");
        // R9: error on second octet
        step(0, 8'h77, 0, "R9");
        step(0, 8'h88, 1, "R9");
        commas(2, "R9");
        step(0, 8'h55, 0, "R9");
        commas(4, "R2");
        // R9: error while waiting
        step(1, 8'hBC, 0, "R4");
        step(0, 8'h10, 1, "R9");
        commas(3, "R9");
        step(0, 8'h20, 0, "R9");
        commas(4, "R2");
        step(0, 8'hC3, 0, "R5");
        step(0, 8'h5A, 0, "R7");
        step(0, 8'h00, 0, "R6");
        step(0, 8'h00, 0, "R6");
        // R1: reset mid-lock returns to the idle outputs
        @(negedge clk);
        compare("R6");
        rst_n = 1'b0;
        m_st = 0; m_cnt = 0; m_pos = 0; m_valid = 0;
        @(negedge clk);
        compare("R1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule